// File: doc/BRIEF.md
# A*N+B Coded Arithmetic Unit

This block adds or multiplies two operands that arrive already held in an arithmetic A*N+B code. All arithmetic is done modulo a base m = 2^c − s. A plain value n is stored as the codeword (A·n + B) mod m, and the code constants are chosen so that A·B equals m.

For addition, the unit sums the two codewords and subtracts B, so the sum stays in the same code. For multiplication, the cross term A·B·(x+y) of the product vanishes modulo m. The product is then a codeword of a second code C·N+D, with C = A² and D = B² mod m. No correction adder is needed.

Each result is checked against the set of legal codewords for the operation that produced it. Any value outside that set raises an error flag. A table decoder recovers the plain value of every accepted result. The defaults are c = 4, s = 1, A = 3 and B = 5. With these, m = 15, the plain range is 0..4, and arithmetic on plain values wraps modulo 5.

Top module: `abn_alu`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, res_code, res_err and res_plain are all 0.
- R2: The operands and op_mul are sampled on a rising edge of clk. The outputs for them appear after that edge and hold until the next rising edge.
- R3: With op_mul = 0, res_code = ((x_code mod 15) + (y_code mod 15) − 5) mod 15. For the codewords of plain a and b, this is the codeword 3·((a+b) mod 5) + 5.
- R4: With op_mul = 1, res_code = ((x_code mod 15)·(y_code mod 15)) mod 15. For the codewords of plain a and b, this is (9·((a·b) mod 5) + 10) mod 15.
- R5: After an add, res_err is 1 exactly when res_code is not one of the legal values. The legal values are (3·n + 5) mod 15 for n = 0..4, that is {5, 8, 11, 14, 2}.
- R6: After a multiply, res_err is 1 exactly when res_code is not one of the legal values. The legal values are (9·n + 10) mod 15 for n = 0..4, that is {10, 4, 13, 7, 1}.
- R7: The value 0 is never a legal result, so an add whose result is 0 always raises res_err.
- R8: When res_err is 0, res_plain is the n in 0..4 whose codeword, for the operation that produced the result, equals res_code. When res_err is 1, res_plain is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_mul | input | 1 | Operation select: 0 add, 1 multiply |
| x_code | input | CW | First coded operand |
| y_code | input | CW | Second coded operand |
| res_code | output | CW | Registered coded result |
| res_err | output | 1 | Registered code-membership error flag |
| res_plain | output | PW | Registered decoded plain value of the result |

## Verification
The bench builds the unit with its default code: c = 4, s = 1, A = 3, B = 5. With these values the whole operand space is only 16 × 16 values per operation, so the bench drives every pair through both the adder and the multiplier. This sweep reaches every legal codeword. It also reaches every illegal operand value, including the residue alias 15 and the zero word. Both error sets and both decoder tables are therefore covered in full. A second sweep over plain values 0..4 confirms that addition wraps modulo 5 and multiplication wraps modulo 5.

// File: rtl/abn_pkg.sv
package abn_pkg;

  // codeword of plain value n in the code mul*N+off, modulo m
  function automatic int code_of(int n, int mul, int off, int m);
    return (mul * n + off) % m;
  endfunction

  // coded sum: both operands reduced, offset removed once
  function automatic int coded_sum(int a, int b, int off, int m);
    return ((a % m) + (b % m) + (m - off)) % m;
  endfunction

  // coded product: plain residue product, cross term vanishes since A*B = m
  function automatic int coded_prod(int a, int b, int m);
    return ((a % m) * (b % m)) % m;
  endfunction

  // index of the plain value whose codeword equals r, or -1
  function automatic int plain_of(int r, int mul, int off, int m, int k);
    int hit;
    hit = -1;
    for (int n = 0; n < k; n++) begin
      if (code_of(n, mul, off, m) == r) hit = n;
    end
    return hit;
  endfunction

endpackage

// File: rtl/abn_mod_add.sv
module abn_mod_add #(
  parameter int CW  = 4,
  parameter int MOD = 15,
  parameter int OFF = 5
) (
  input  logic [CW-1:0] a,
  input  logic [CW-1:0] b,
  output logic [CW-1:0] sum
);
  import abn_pkg::*;

  always_comb begin
    sum = CW'(coded_sum(int'(a), int'(b), OFF, MOD));
  end

endmodule

// File: rtl/abn_mod_mul.sv
module abn_mod_mul #(
  parameter int CW  = 4,
  parameter int MOD = 15
) (
  input  logic [CW-1:0] a,
  input  logic [CW-1:0] b,
  output logic [CW-1:0] prod
);
  import abn_pkg::*;

  always_comb begin
    prod = CW'(coded_prod(int'(a), int'(b), MOD));
  end

endmodule

// File: rtl/abn_code_lut.sv
module abn_code_lut #(
  parameter int CW  = 4,
  parameter int MOD = 15,
  parameter int MUL = 3,
  parameter int OFF = 5,
  parameter int K   = 5,
  parameter int PW  = 3
) (
  input  logic [CW-1:0] code,
  output logic          legal,
  output logic [PW-1:0] plain
);
  import abn_pkg::*;

  localparam int NCODE = 1 << CW;

  logic [NCODE-1:0] legal_mask;
  logic [PW-1:0]    plain_tab [NCODE];

  // one table entry per c-bit pattern, filled at elaboration
  for (genvar g = 0; g < NCODE; g++) begin : g_ent
    localparam int IDX = plain_of(g, MUL, OFF, MOD, K);
    assign legal_mask[g] = (IDX >= 0);
    assign plain_tab[g]  = PW'((IDX < 0) ? 0 : IDX);
  end

  assign legal = legal_mask[code];
  assign plain = plain_tab[code];

endmodule

// File: rtl/abn_alu.sv
module abn_alu #(
  parameter  int CW  = 4,
  parameter  int S   = 1,
  parameter  int A   = 3,
  parameter  int B   = 5,
  localparam int MOD = (1 << CW) - S,
  localparam int K   = MOD / A,
  localparam int PW  = $clog2(K)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_mul,
  input  logic [CW-1:0] x_code,
  input  logic [CW-1:0] y_code,
  output logic [CW-1:0] res_code,
  output logic          res_err,
  output logic [PW-1:0] res_plain
);

  // product code constants
  localparam int C = (A * A) % MOD;
  localparam int D = (B * B) % MOD;

  logic [CW-1:0] add_res;
  logic [CW-1:0] mul_res;
  logic          add_ok;
  logic          mul_ok;
  logic [PW-1:0] add_plain;
  logic [PW-1:0] mul_plain;
  logic [CW-1:0] sel_res;
  logic          sel_err;
  logic [PW-1:0] sel_plain;

  abn_mod_add #(.CW(CW), .MOD(MOD), .OFF(B)) u_add (
    .a(x_code), .b(y_code), .sum(add_res)
  );

  abn_mod_mul #(.CW(CW), .MOD(MOD)) u_mul (
    .a(x_code), .b(y_code), .prod(mul_res)
  );

  abn_code_lut #(.CW(CW), .MOD(MOD), .MUL(A), .OFF(B), .K(K), .PW(PW)) u_add_chk (
    .code(add_res), .legal(add_ok), .plain(add_plain)
  );

  abn_code_lut #(.CW(CW), .MOD(MOD), .MUL(C), .OFF(D), .K(K), .PW(PW)) u_mul_chk (
    .code(mul_res), .legal(mul_ok), .plain(mul_plain)
  );

  always_comb begin
    sel_res   = op_mul ? mul_res : add_res;
    sel_err   = op_mul ? !mul_ok : !add_ok;
    sel_plain = sel_err ? '0 : (op_mul ? mul_plain : add_plain);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_code  <= '0;
      res_err   <= 1'b0;
      res_plain <= '0;
    end else begin
      res_code  <= sel_res;
      res_err   <= sel_err;
      res_plain <= sel_plain;
    end
  end

endmodule

// File: rtl/abn_alu_sva.sv
module abn_alu_sva #(
  parameter int CW = 4,
  parameter int S  = 1,
  parameter int A  = 3,
  parameter int B  = 5,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_mul,
  input logic [CW-1:0] x_code,
  input logic [CW-1:0] y_code,
  input logic [CW-1:0] res_code,
  input logic          res_err,
  input logic [PW-1:0] res_plain,
  input logic          add_ok,
  input logic          mul_ok
);
  localparam int M  = (1 << CW) - S;
  localparam int CC = (A * A) % M;
  localparam int DD = (B * B) % M;

  function automatic bit in_add_code(int v);
    if (v >= M) return 1'b0;
    return (((v + M - B) % M) % A) == 0;
  endfunction

  function automatic bit in_mul_code(int v);
    bit f;
    f = 1'b0;
    for (int n = 0; n < M / A; n++) begin
      if ((CC * n + DD) % M == v) f = 1'b1;
    end
    return f;
  endfunction

  // R3
  add_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_mul && in_add_code(int'(x_code)) && in_add_code(int'(y_code)))
    |=> (!res_err && in_add_code(int'(res_code))));

  // R4
  mul_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mul && in_add_code(int'(x_code)) && in_add_code(int'(y_code)))
    |=> (!res_err && in_mul_code(int'(res_code))));

  // R5
  add_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_mul |=> (res_err == !in_add_code(int'(res_code))));

  // R6
  mul_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_mul |=> (res_err == !in_mul_code(int'(res_code))));

  // R7
  no_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_mul |=> (res_err || res_code != '0));

  // R8
  plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_mul |=> (res_err || ((A * int'(res_plain) + B) % M == int'(res_code))));

  // R8
  err_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> (res_plain == '0));

  // R5
  lut_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_mul && add_ok) |=> !res_err);

  // R6
  lut_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mul && !mul_ok) |=> res_err);

endmodule

bind abn_alu abn_alu_sva #(.CW(CW), .S(S), .A(A), .B(B), .PW(PW)) u_abn_alu_sva (
  .clk(clk), .rst_n(rst_n), .op_mul(op_mul), .x_code(x_code), .y_code(y_code),
  .res_code(res_code), .res_err(res_err), .res_plain(res_plain),
  .add_ok(add_ok), .mul_ok(mul_ok)
);

// File: tb/abn_alu_bench.sv
module abn_alu_bench;
  localparam int CW = 4;
  localparam int PW = 3;
  localparam int M  = 15;
  localparam int KA = 3;
  localparam int KB = 5;
  localparam int KC = 9;
  localparam int KD = 10;
  localparam int NP = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_mul = 1'b0;
  logic [CW-1:0] x_code = '0;
  logic [CW-1:0] y_code = '0;
  logic [CW-1:0] res_code;
  logic          res_err;
  logic [PW-1:0] res_plain;

  int checks = 0;
  int errors = 0;
  int prev_code = 0;
  int prev_err  = 0;
  int prev_plain = 0;

  always #4 clk = ~clk;

  abn_alu u_abn_alu (
    .clk(clk), .rst_n(rst_n), .op_mul(op_mul), .x_code(x_code), .y_code(y_code),
    .res_code(res_code), .res_err(res_err), .res_plain(res_plain)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reduce by repeated subtraction
  function automatic int wrap(int v);
    int r;
    r = v;
    while (r < 0) r += M;
    while (r >= M) r -= M;
    return r;
  endfunction

  // search table of legal codewords for one code
  function automatic int find_plain(int r, int mul, int off);
    int hit;
    hit = -1;
    for (int n = 0; n < NP; n++) if (wrap(mul * n + off) == r) hit = n;
    return hit;
  endfunction

  task automatic step(bit op, int x, int y, int plain_exp);
    int rc;
    int hit;
    int e_err;
    int e_plain;
    op_mul = op;
    x_code = CW'(x);
    y_code = CW'(y);
    #1;
    check("R2 hold code", int'(res_code), prev_code);
    check("R2 hold err", int'(res_err), prev_err);
    if (op) rc = wrap(wrap(x) * wrap(y));
    else    rc = wrap(wrap(x) + wrap(y) - KB);
    hit = op ? find_plain(rc, KC, KD) : find_plain(rc, KA, KB);
    e_err   = (hit < 0) ? 1 : 0;
    e_plain = (hit < 0) ? 0 : hit;
    @(negedge clk);
    if (op) begin
      check("R4 code", int'(res_code), rc);
      check("R6 err", int'(res_err), e_err);
    end else begin
      check("R3 code", int'(res_code), rc);
      if (rc == 0) check("R7 zero flagged", int'(res_err), 1);
      else         check("R5 err", int'(res_err), e_err);
    end
    check("R8 plain", int'(res_plain), e_plain);
    if (plain_exp >= 0) check(op ? "R4 plain wrap" : "R3 plain wrap", int'(res_plain), plain_exp);
    prev_code  = rc;
    prev_err   = e_err;
    prev_plain = e_plain;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    op_mul = 1'b1;
    x_code = 4'd7;
    y_code = 4'd9;
    repeat (3) @(negedge clk);
    check("R1 reset code", int'(res_code), 0);
    check("R1 reset err", int'(res_err), 0);
    check("R1 reset plain", int'(res_plain), 0);
    rst_n = 1'b1;
    op_mul = 1'b0;
    // plain-value sweep over all codeword pairs
    for (int a = 0; a < NP; a++) begin
      for (int b = 0; b < NP; b++) begin
        step(1'b0, wrap(KA * a + KB), wrap(KA * b + KB), (a + b) % NP);
        step(1'b1, wrap(KA * a + KB), wrap(KA * b + KB), (a * b) % NP);
      end
    end
    // exhaustive raw operand sweep, including illegal words and the alias 15
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        step(1'b0, x, y, -1);
        step(1'b1, x, y, -1);
      end
    end
    // reset again mid-stream
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset code again", int'(res_code), 0);
    check("R1 reset err again", int'(res_err), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule